// File: doc/BRIEF.md
# Pulse Period Sweep Unit

This block moves the 11-bit timer period of a pulse tone channel up or down at a slow, programmable rate. Software writes one setup byte. The frame sequencer supplies a half-frame clock enable. The channel's pulse timer supplies its current period. From these the block works out a target period, which is the current period plus or minus a right-shifted copy of itself. On selected half-frame ticks it raises a write strobe so the timer can load that target.

The block also decides when the channel must be silenced. A very short period, or an upward sweep that would overflow 11 bits, mutes the channel. This mute check runs continuously, whether sweeping is enabled or not, and it never alters the period. A parameter picks between the two channel variants. The first variant negates with one's complement, so a downward step removes one extra count. The second negates with two's complement.

Top module: `pulse_sweep`

## Requirements
- R1: Setup byte fields are: bit 7 enable, bits 6-4 divider field P, bit 3 negate, bits 2-0 shift count S. A write stores all four fields at the clock edge.
- R2: A setup write sets a reload flag. On the next half-frame tick the divider is clocked first, then reloaded with P, and the flag is cleared.
- R3: The divider is a 3-bit down-counter, reset to 0. On a tick where it reads 0, it emits a sweep clock and reloads with P; on any other tick it decrements. With no reload pending, sweep clocks therefore come every P+1 ticks.
- R4: With negate = 0, target = period + (period >> S), computed to 12 bits.
- R5: With negate = 1, the target is taken modulo 2^11. Variant 1 (ONES_NEG=1) gives period - (period >> S) - 1, and variant 2 (ONES_NEG=0) gives period - (period >> S).
- R6: mute is 1 whenever the period is below 8 or the 12-bit add target exceeds 0x7FF. This holds regardless of enable, shift count or tick. A negated target never raises mute by itself.
- R7: period_we is 1 only during a tick cycle in which the divider emits a clock, enable is set, S is non-zero and mute is 0. new_period always shows the low 11 bits of the target.
- R8: new_period and mute follow cur_period combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup byte write strobe |
| cfg_data | input | 8 | Setup byte (enable, P, negate, shift) |
| half_tick | input | 1 | Half-frame clock enable, one cycle wide |
| cur_period | input | 11 | Channel's current timer period |
| new_period | output | 11 | Target period (low 11 bits) |
| period_we | output | 1 | Load strobe for the channel timer |
| mute | output | 1 | Silence request to the mixer path |

## Verification
The hardest state to reach is the phase of the divider at a given tick. The counter is invisible at the ports, and its phase depends on the whole history of writes and ticks, including the reload that follows a write. The bench therefore keeps its own model of the counter and reload flag. It drives every P value through several sweep periods while feeding period_we back into the period, so each strobe is predicted from the modelled phase. The target and mute arithmetic is covered exhaustively for every shift, sign and 11-bit period, on both variants.

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
  parameter bit ONES_NEG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_data,
  input  logic        half_tick,
  input  logic [10:0] cur_period,
  output logic [10:0] new_period,
  output logic        period_we,
  output logic        mute
);
  logic        en_q, neg_q, reload_q;
  logic [2:0]  per_q, sh_q, cnt_q;
  logic [10:0] shifted, addend;
  logic [11:0] sum;
  logic        fire, over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 3'd0;
      neg_q    <= 1'b0;
      sh_q     <= 3'd0;
      cnt_q    <= 3'd0;
      reload_q <= 1'b0;
    end else begin
      if (cfg_we) {en_q, per_q, neg_q, sh_q} <= cfg_data;
      if (half_tick) cnt_q <= (reload_q || cnt_q == 3'd0) ? per_q : cnt_q - 3'd1;
      if (cfg_we) reload_q <= 1'b1;
      else if (half_tick) reload_q <= 1'b0;
    end
  end

  assign fire       = half_tick && (cnt_q == 3'd0);
  assign shifted    = cur_period >> sh_q;
  assign addend     = neg_q ? ~shifted : shifted;
  assign sum        = {1'b0, cur_period} + {1'b0, addend} + {11'd0, neg_q && !ONES_NEG};
  assign over       = !neg_q && sum[11];
  assign mute       = (cur_period < 11'd8) || over;
  assign new_period = sum[10:0];
  assign period_we  = fire && en_q && (sh_q != 3'd0) && !mute;

  // R2
  reload_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> reload_q);
  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && cnt_q == 3'd0) |=> cnt_q == $past(per_q));
  // R3
  div_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !reload_q && cnt_q != 3'd0) |=> cnt_q == $past(cnt_q) - 3'd1);
  // R6
  short_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_period < 11'd8) |-> mute);
  // R6
  neg_no_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_q && cur_period >= 11'd8) |-> !mute);
  // R7
  we_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_we |-> (half_tick && cur_period >= 11'd8));
endmodule

// File: tb/tb_pulse_sweep.sv
`timescale 1ns/100ps
module tb_pulse_sweep;
  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, half_tick = 1'b0;
  logic [7:0]  cfg_data = 8'd0;
  logic [10:0] cur1 = 11'h100, cur2 = 11'h100;
  logic [10:0] np1, np2;
  logic        we1, we2, mu1, mu2;
  int vecs = 0, bad = 0, cyc = 0;
  logic       men = 0, mneg = 0, mrel = 0;
  logic [2:0] mper = 0, msh = 0, mcnt = 0;

  always #2.5 clk = ~clk;

  pulse_sweep #(.ONES_NEG(1'b1)) dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .half_tick(half_tick), .cur_period(cur1), .new_period(np1), .period_we(we1), .mute(mu1));
  pulse_sweep #(.ONES_NEG(1'b0)) dut_v2 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .half_tick(half_tick), .cur_period(cur2), .new_period(np2), .period_we(we2), .mute(mu2));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  function automatic int tgt(int c, int s, bit n, bit v1);
    int sv = c >> s;
    if (!n) return c + sv;
    return (c + 4096 - sv - (v1 ? 1 : 0)) % 2048;
  endfunction

  function automatic bit mref(int c, int s, bit n, bit v1);
    return (c < 8) || (tgt(c, s, n, v1) > 2047);
  endfunction

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = d;
    @(posedge clk);
    {men, mper, mneg, msh} = d;
    mrel = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(int gap);
    bit f, e1, e2;
    int t1, t2;
    @(negedge clk);
    half_tick = 1'b1;
    #1;
    f  = (mcnt == 3'd0);
    t1 = tgt(cur1, msh, mneg, 1'b1);
    t2 = tgt(cur2, msh, mneg, 1'b0);
    e1 = f && men && msh != 0 && !mref(cur1, msh, mneg, 1'b1);
    e2 = f && men && msh != 0 && !mref(cur2, msh, mneg, 1'b0);
    chk("R3/R7 v1 period_we", we1, e1);
    chk("R3/R7 v2 period_we", we2, e2);
    chk("R7 v1 new_period", np1, t1 % 2048);
    chk("R7 v2 new_period", np2, t2 % 2048);
    chk("R6 v1 mute", mu1, mref(cur1, msh, mneg, 1'b1));
    @(posedge clk);
    mcnt = f ? mper : mcnt - 3'd1;
    if (mrel) begin mrel = 1'b0; mcnt = mper; end
    @(negedge clk);
    half_tick = 1'b0;
    if (e1) cur1 = 11'(t1);
    if (e2) cur2 = 11'(t2);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R7 no strobe without tick", we1 | we2, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset period_we", we1, 0);
    chk("R4 reset target add S=0", np1, 11'h200);
    chk("R6 reset mute", mu1, 0);
    tick(1);

    for (int n = 0; n < 2; n++)
      for (int s = 0; s < 8; s++) begin
        wr({1'b0, 3'd5, n[0], s[2:0]});
        for (int c = 0; c < 2048; c++) begin
          cur1 = 11'(c); cur2 = 11'(c);
          #1;
          if (n == 0) chk("R4 add target", np1, tgt(c, s, 0, 1) % 2048);
          else begin
            chk("R5 v1 ones-complement target", np1, tgt(c, s, 1, 1));
            chk("R5 v2 twos-complement target", np2, tgt(c, s, 1, 0));
          end
          chk("R6 R8 v1 mute", mu1, mref(c, s, n[0], 1));
          chk("R6 R8 v2 mute", mu2, mref(c, s, n[0], 0));
          chk("R6 no strobe when disabled", we1 | we2, 0);
        end
      end

    for (int p = 0; p < 8; p++) begin
      cur1 = 11'h040; cur2 = 11'h040;
      wr({1'b1, p[2:0], 1'b0, 3'd3});
      for (int k = 0; k < 3 * (p + 1) + 2; k++) tick(k % 3);
    end
    cur1 = 11'h7F0; cur2 = 11'h7F0;
    wr({1'b1, 3'd1, 1'b1, 3'd2});
    for (int k = 0; k < 12; k++) tick(1);
    wr({1'b1, 3'd0, 1'b1, 3'd0});
    for (int k = 0; k < 4; k++) tick(0);
    cur1 = 11'h600; cur2 = 11'h600;
    wr({1'b1, 3'd0, 1'b0, 3'd1});
    for (int k = 0; k < 4; k++) tick(0);
    cur1 = 11'd4; cur2 = 11'd4;
    wr({1'b1, 3'd0, 1'b1, 3'd1});
    for (int k = 0; k < 4; k++) tick(0);
    cur1 = 11'h100; cur2 = 11'h100;
    wr({1'b0, 3'd2, 1'b0, 3'd1});
    for (int k = 0; k < 6; k++) tick(1);
    wr({1'b1, 3'd6, 1'b0, 3'd4});
    for (int k = 0; k < 3; k++) tick(0);
    wr({1'b1, 3'd2, 1'b1, 3'd4});
    for (int k = 0; k < 10; k++) tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule